// File: doc/BRIEF.md
# I2S Stereo Receive Channel Pair

This block captures one stereo pair from an I2S serial link and queues it for software. The serial clock, word select and data arrive as plain inputs and are sampled in the system clock domain. On each rising edge of the serial clock the block takes one data bit. Word select leads the data by one bit slot. A word-select change therefore marks the last bit of the word just ending, and the next bit is the most significant bit of the other channel.

Each word is cut to a programmed resolution. The block holds the left word until the matching right word is complete, then writes the pair into a FIFO as one entry. Software reads the oldest entry through two buffer addresses on a simple register port. An interrupt line combines a data-available source, raised when the fill level passes a programmable threshold, and a sticky overrun source. Each source has its own mask bit.

Top module: `aud_rx_pair`

## Requirements
- R1: After reset the FIFO is empty, status (0x38) reads 0, both interrupt masks (0x3C bits 1:0) are set, and `irq_o` is low.
- R2: With the block and channel enabled, a word sent MSB first while word select is 0 is the left sample and one sent while it is 1 is the right sample. Each pair is readable as left at 0x20 and right at 0x24, right-justified and zero-extended.
- R3: The resolution register (0x30, bits 2:0) keeps the first 16 bits of each word for code 2, 24 bits for code 4 and 32 bits for code 5. Every other code keeps 32 bits. Bits past the resolution are ignored.
- R4: Reading 0x24 removes the oldest entry. Reading 0x20 leaves the FIFO unchanged. Either address reads 0 while the FIFO is empty.
- R5: Status bit 0 (data available) is 1 exactly when the FIFO level is greater than the threshold register (0x48).
- R6: A pair that completes while the FIFO is full (8 entries) is discarded, the stored entries are unchanged, and status bit 1 (overrun) is set.
- R7: A read of 0x40 returns the overrun flag in bit 0 and clears it.
- R8: `irq_o` is high when data-available is set and mask bit 0 is 0, or when overrun is set and mask bit 1 is 0.
- R9: Writing 1 to bit 0 of 0x14 empties the FIFO.
- R10: Pairs are captured only while both the block enable (0x04 bit 0) and the channel enable (0x28 bit 0) are 1. After enabling, capture starts with the first word that begins after a word-select change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock, slower than clk |
| ws_i | input | 1 | Word select: 0 left, 1 right |
| sd_i | input | 1 | Serial data |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe; pop and clear take effect at the clock edge |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Combined, masked interrupt |

## Verification
The hardest state to reach is a pair that completes against a full FIFO. A discarded pair must leave the eight stored entries untouched while the overrun flag rises. The stimulus reaches this by raising the threshold, streaming nine back-to-back frames with no reads, and then draining the FIFO and comparing every entry with the first eight frames sent. Frame alignment is the second delicate case. Enable changes happen between frames and are followed by a short word-select preamble, so that the partial first word is shown to be dropped rather than queued.

// File: rtl/aud_rx_pkg.sv
// Shared register offsets and resolution decoding for the I2S receive pair.
// Assumes a byte-addressed register port whose addresses fit in 8 bits.
package aud_rx_pkg;
    localparam logic [7:0] A_BLK_EN = 8'h04;
    localparam logic [7:0] A_FLUSH  = 8'h14;
    localparam logic [7:0] A_LEFT   = 8'h20;
    localparam logic [7:0] A_RIGHT  = 8'h24;
    localparam logic [7:0] A_CH_EN  = 8'h28;
    localparam logic [7:0] A_RES    = 8'h30;
    localparam logic [7:0] A_STAT   = 8'h38;
    localparam logic [7:0] A_MASK   = 8'h3C;
    localparam logic [7:0] A_OVR    = 8'h40;
    localparam logic [7:0] A_THR    = 8'h48;

    localparam logic [2:0] RES_16 = 3'd2;
    localparam logic [2:0] RES_24 = 3'd4;
    localparam logic [2:0] RES_32 = 3'd5;

    // Number of bits kept per word for a resolution code; unknown codes keep 32.
    function automatic logic [5:0] res_to_bits(input logic [2:0] code);
        case (code)
            RES_16:  return 6'd16;
            RES_24:  return 6'd24;
            default: return 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/aud_rx_deser.sv
// Serial-to-parallel stage: samples sd_i on rising sclk_i edges (detected in
// the clk domain), splits words on word-select changes, keeps the first
// res bits of each word and emits a one-cycle pulse with a left/right pair.
// Assumes sclk_i is slow enough that each level lasts at least two clk cycles.
module aud_rx_deser #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [2:0]   res_code_i,
    input  logic         sclk_i,
    input  logic         ws_i,
    input  logic         sd_i,
    output logic         pair_valid_o,
    output logic [W-1:0] pair_left_o,
    output logic [W-1:0] pair_right_o
);
    localparam int CW = $clog2(W + 1);

    logic          sclk_q;
    logic          ws_prev;
    logic          synced;
    logic          lvalid;
    logic [CW-1:0] cnt;
    logic [CW-1:0] res_lim;
    logic [W-1:0]  sh;
    logic [W-1:0]  lhold;
    logic [W-1:0]  last_word;
    logic          rise;

    assign res_lim   = CW'(aud_rx_pkg::res_to_bits(res_code_i));
    assign rise      = sclk_i & ~sclk_q;
    assign last_word = (cnt < res_lim) ? {sh[W-2:0], sd_i} : sh;

    // Previous serial clock level, used for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    // Bit collection, word framing and pair assembly on each serial rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev      <= 1'b0;
            synced       <= 1'b0;
            lvalid       <= 1'b0;
            cnt          <= '0;
            sh           <= '0;
            lhold        <= '0;
            pair_valid_o <= 1'b0;
            pair_left_o  <= '0;
            pair_right_o <= '0;
        end else begin
            pair_valid_o <= 1'b0;
            if (rise) begin
                if (!run_i) begin
                    synced  <= 1'b0;
                    lvalid  <= 1'b0;
                    cnt     <= '0;
                    sh      <= '0;
                    ws_prev <= ws_i;
                end else if (ws_i != ws_prev) begin
                    ws_prev <= ws_i;
                    synced  <= 1'b1;
                    cnt     <= '0;
                    sh      <= '0;
                    if (synced) begin
                        if (!ws_prev) begin
                            lhold  <= last_word;
                            lvalid <= 1'b1;
                        end else if (lvalid) begin
                            pair_valid_o <= 1'b1;
                            pair_left_o  <= lhold;
                            pair_right_o <= last_word;
                            lvalid       <= 1'b0;
                        end
                    end
                end else if (cnt < res_lim) begin
                    sh  <= {sh[W-2:0], sd_i};
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_PAIR_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |-> $past(run_i)); // R10
    AST_PAIR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |=> !pair_valid_o); // R2
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && run_i && ws_i == ws_prev && cnt >= res_lim) |=> $stable(sh)); // R3
endmodule

// File: rtl/aud_rx_fifo.sv
// Synchronous FIFO of stereo pairs. A push that finds it full (with no pop in
// the same cycle) is dropped and reported on drop_o. Flush wins over push/pop.
// Assumes DEPTH is a power of two.
module aud_rx_fifo #(
    parameter int DW    = 64,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [DW-1:0]                data_i,
    input  logic                         pop_i,
    input  logic                         flush_i,
    output logic [DW-1:0]                data_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o,
    output logic                         drop_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          full;
    logic          pop_ok;
    logic          push_ok;

    assign full    = (level_o == LW'(DEPTH));
    assign pop_ok  = pop_i & (level_o != '0) & ~flush_i;
    assign push_ok = push_i & ~flush_i & (~full | pop_ok);
    assign drop_o  = push_i & ~flush_i & full & ~pop_ok;
    assign data_o  = mem[rd_ptr];

    // Storage write for accepted pairs.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= data_i;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_o <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            level_o <= level_o + LW'(push_ok) - LW'(pop_ok);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LW'(DEPTH)); // R6
    AST_FULL_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> level_o == LW'(DEPTH)); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> level_o == '0); // R9
    AST_EMPTY_POP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && level_o == '0 && !push_i) |=> level_o == '0); // R4
endmodule

// File: rtl/aud_rx_pair.sv
// Top of the I2S stereo receive pair: register port, enables, resolution,
// threshold, masks and sticky overrun around the deserializer and FIFO.
// Assumes reads and writes are single-cycle strobes; read data is combinational.
module aud_rx_pair #(
    parameter int SAMPLE_W   = 32,
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk_i,
    input  logic        ws_i,
    input  logic        sd_i,
    input  logic        bus_wr_i,
    input  logic        bus_rd_i,
    input  logic [7:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o
);
    import aud_rx_pkg::*;

    localparam int LW = $clog2(FIFO_DEPTH + 1);
    localparam int DW = 2 * SAMPLE_W;

    logic          blk_en, ch_en, ovr, avail;
    logic [2:0]    res_code;
    logic [1:0]    mask;
    logic [LW-1:0] thr;
    logic [LW-1:0] level;
    logic          pv, drop, pop, flush, ovr_clr;
    logic [SAMPLE_W-1:0] pl, pr;
    logic [DW-1:0] head;

    aud_rx_deser #(.W(SAMPLE_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .run_i(blk_en & ch_en), .res_code_i(res_code),
        .sclk_i(sclk_i), .ws_i(ws_i), .sd_i(sd_i),
        .pair_valid_o(pv), .pair_left_o(pl), .pair_right_o(pr)
    );

    aud_rx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(pv), .data_i({pl, pr}),
        .pop_i(pop), .flush_i(flush), .data_o(head), .level_o(level), .drop_o(drop)
    );

    assign pop     = bus_rd_i & (bus_addr_i == A_RIGHT);
    assign ovr_clr = bus_rd_i & (bus_addr_i == A_OVR);
    assign flush   = bus_wr_i & (bus_addr_i == A_FLUSH) & bus_wdata_i[0];
    assign avail   = (level > thr);
    assign irq_o   = (avail & ~mask[0]) | (ovr & ~mask[1]);

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_en   <= 1'b0;
            ch_en    <= 1'b0;
            res_code <= RES_32;
            mask     <= 2'b11;
            thr      <= '0;
        end else if (bus_wr_i) begin
            case (bus_addr_i)
                A_BLK_EN: blk_en   <= bus_wdata_i[0];
                A_CH_EN:  ch_en    <= bus_wdata_i[0];
                A_RES:    res_code <= bus_wdata_i[2:0];
                A_MASK:   mask     <= bus_wdata_i[1:0];
                A_THR:    thr      <= bus_wdata_i[LW-1:0];
                default:  ;
            endcase
        end
    end

    // Sticky overrun: set by a dropped pair, cleared by reading its register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (drop)    ovr <= 1'b1;
        else if (ovr_clr) ovr <= 1'b0;
    end

    // Register read multiplexer.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_BLK_EN: bus_rdata_o = {31'd0, blk_en};
            A_CH_EN:  bus_rdata_o = {31'd0, ch_en};
            A_RES:    bus_rdata_o = {29'd0, res_code};
            A_MASK:   bus_rdata_o = {30'd0, mask};
            A_THR:    bus_rdata_o = 32'(thr);
            A_STAT:   bus_rdata_o = {30'd0, ovr, avail};
            A_OVR:    bus_rdata_o = {31'd0, ovr};
            A_LEFT:   bus_rdata_o = (level != '0) ? 32'(head[DW-1:SAMPLE_W]) : '0;
            A_RIGHT:  bus_rdata_o = (level != '0) ? 32'(head[SAMPLE_W-1:0]) : '0;
            default:  bus_rdata_o = '0;
        endcase
    end

    AST_OVR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !drop) |=> !ovr); // R7
    AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovr); // R6
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b11) |-> !irq_o); // R8
endmodule

// File: tb/aud_rx_pair_tb.sv
`timescale 1ns/1ps
// Bench: behavioural queue model of the receive pair, irq compared every clock
// while the model is settled, register reads compared against the queue.
module aud_rx_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, ws = 1'b0, sd = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #5 clk = ~clk;

    aud_rx_pair dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .ws_i(ws), .sd_i(sd),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    int nvec = 0, nerr = 0;
    bit live = 0, done = 0;

    logic [63:0] q[$];
    int  m_thr = 0;
    int  m_bits = 32;
    bit  m_ovr = 0, m_blk = 0, m_ch = 0;
    logic [1:0] m_mask = 2'b11;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit exp_irq();
        return ((q.size() > m_thr) && !m_mask[0]) || (m_ovr && !m_mask[1]);
    endfunction

    // Per-clock comparison of the interrupt line against the model.
    always @(negedge clk) begin
        if (live && rst_n && !done) check("R8 irq", {31'd0, irq}, {31'd0, exp_irq()});
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1 wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
        @(posedge clk); #1 rd = 1'b0;
    endtask

    task automatic slot(input logic w, input logic d);
        @(negedge clk); sclk = 1'b0; ws = w; sd = d;
        @(negedge clk); sclk = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic preamble();
        live = 0;
        for (int i = 0; i < 3; i++) slot(1'b1, 1'b0);
        slot(1'b0, 1'b1);
        live = 1;
    endtask

    task automatic frame(input logic [31:0] l, input logic [31:0] r);
        live = 0;
        for (int i = 0; i < 32; i++) slot(i == 31, l[31-i]);
        for (int i = 0; i < 32; i++) slot(i != 31, r[31-i]);
        if (m_blk && m_ch) begin
            if (q.size() < 8) q.push_back({32'(l >> (32 - m_bits)), 32'(r >> (32 - m_bits))});
            else m_ovr = 1;
        end
        live = 1;
    endtask

    task automatic check_status(input string req);
        logic [31:0] d;
        bus_read(8'h38, d);
        check(req, d, {30'd0, m_ovr, q.size() > m_thr});
    endtask

    task automatic read_pair(input string req);
        logic [31:0] d;
        logic [63:0] e;
        e = (q.size() > 0) ? q[0] : 64'd0;
        bus_read(8'h20, d);
        check({req, " left"}, d, e[63:32]);
        bus_read(8'h24, d);
        if (q.size() > 0) void'(q.pop_front());
        check({req, " right"}, d, e[31:0]);
    endtask

    task automatic set_res(input logic [2:0] code, input int bits);
        bus_write(8'h30, {29'd0, code});
        m_bits = bits;
    endtask

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_status("R1 status");
        bus_read(8'h3C, d); check("R1 mask", d, 32'd3);
        bus_read(8'h24, d); check("R1 empty right", d, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        live = 1;

        bus_write(8'h3C, 32'd0); m_mask = 2'b00;
        bus_write(8'h04, 32'd1); m_blk = 1;
        bus_write(8'h28, 32'd1); m_ch = 1;
        preamble();
        // R2 basic 32-bit capture
        frame(32'h8123_4567, 32'hFEDC_BA91);
        check_status("R5 avail at level 1");
        // R4 left read does not pop
        bus_read(8'h20, d); check("R4 left peek", d, 32'h8123_4567);
        read_pair("R2 pair");
        check_status("R4 empty after pop");
        bus_read(8'h20, d); check("R4 empty left", d, 32'd0);

        // R3 resolutions
        set_res(3'd2, 16); frame(32'hABCD_1234, 32'h5678_9ABC); read_pair("R3 16-bit");
        set_res(3'd4, 24); frame(32'h1357_9BDF, 32'hF0E1_D2C3); read_pair("R3 24-bit");
        set_res(3'd0, 32); frame(32'h0000_0001, 32'h8000_0000); read_pair("R3 other code");
        set_res(3'd5, 32);

        // R5 threshold
        bus_write(8'h48, 32'd2); m_thr = 2;
        frame(32'h1111_0001, 32'h2222_0001);
        frame(32'h1111_0002, 32'h2222_0002);
        check_status("R5 below threshold");
        frame(32'h1111_0003, 32'h2222_0003);
        check_status("R5 above threshold");
        while (q.size() > 0) read_pair("R5 drain");

        // R6/R7 overrun
        bus_write(8'h48, 32'd7); m_thr = 7;
        for (int i = 0; i < 9; i++) frame(32'hC000_0000 + i, 32'h0D00_0000 + i);
        check_status("R6 overrun and full");
        bus_read(8'h40, d); check("R7 overrun read", d, 32'd1); m_ovr = 0;
        bus_read(8'h40, d); check("R7 overrun cleared", d, 32'd0);
        check_status("R7 status after clear");
        while (q.size() > 0) read_pair("R6 kept entries");

        // R8 masks
        bus_write(8'h48, 32'd0); m_thr = 0;
        frame(32'h7777_0000, 32'h8888_0000);
        bus_write(8'h3C, 32'd1); m_mask = 2'b01;
        check("R8 masked avail", {31'd0, irq}, 32'd0);
        bus_write(8'h3C, 32'd0); m_mask = 2'b00;
        check("R8 unmasked avail", {31'd0, irq}, 32'd1);

        // R9 flush
        frame(32'h9999_0001, 32'hAAAA_0001);
        frame(32'h9999_0002, 32'hAAAA_0002);
        bus_write(8'h14, 32'd1); q.delete();
        check_status("R9 flushed");
        bus_read(8'h24, d); check("R9 empty after flush", d, 32'd0);

        // R10 enables
        bus_write(8'h28, 32'd0); m_ch = 0;
        frame(32'hDEAD_0001, 32'hBEEF_0001);
        check_status("R10 channel disabled");
        bus_write(8'h28, 32'd1); m_ch = 1;
        bus_write(8'h04, 32'd0); m_blk = 0;
        frame(32'hDEAD_0002, 32'hBEEF_0002);
        check_status("R10 block disabled");
        bus_write(8'h04, 32'd1); m_blk = 1;
        preamble();
        check_status("R10 no partial pair");
        frame(32'hDEAD_0003, 32'hBEEF_0003);
        read_pair("R10 re-enabled");
        check_status("R10 final empty");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule